// File: doc/BRIEF.md
# Vending Order Controller

This block runs one vending sale at a time as a four-state Moore machine. While idle it waits for a purchase request that carries an item number. It then collects coded coins or notes until the running credit covers the item's price. It presents the item number to an external preparation unit and holds it there until that unit reports the item is done. Last, it pays the surplus back one denomination code per clock and closes the sale with a one-cycle end-of-change pulse.

Item prices and denomination values are fixed and computed inside the block. All outputs are decoded from registered state, meaning the phase register, the latched item, the credit and the remaining change. No input reaches an output in the same cycle.

Top module: `vend_order_ctrl`

## Requirements
- R1: After reset, `busy`, `item_out_valid`, `change_valid` and `change_done` are all low, and `item_out` and `change_code` are zero.
- R2: While idle, a purchase is accepted only when `buy` is high and `item_sel` holds 1 to 8. `busy` is then high from the following cycle. Codes 0 and 9 to 15, or `buy` low, leave the block idle.
- R3: Coin codes 1 to 7 are worth 1, 2, 5, 10, 20, 50 and 200 units. The codes 0 and 8 to 15 add nothing to the credit.
- R4: The price of item n is 10·n+5 units. Credit is added on every clock edge of the payment phase that sees `coin_valid`. The phase is left on the first edge at which the registered credit already equals or exceeds the price, and the coin on that same edge is still counted. Coins after that edge are not counted.
- R5: Credit saturates at 2^CREDIT_W−1 (255 by default) and does not wrap.
- R6: In the delivery phase, `item_out` shows the latched item with `item_out_valid` high and `change_valid` low. This holds, with the value unchanged, until `item_ready` is sampled high.
- R7: Change equals credit minus price. It is paid one code per cycle with `change_valid` high. Each code is the largest denomination from R3 that does not exceed the amount still owed.
- R8: Once nothing is owed, `change_done` is high for exactly one cycle, with no change codes when the change is zero. The block is idle, with `busy` low, in the next cycle.
- R9: `busy` is high in the payment, delivery and change phases. When `busy` is low, no valid strobe or end pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| coin_code | input | 4 | Denomination code of an inserted coin or note |
| coin_valid | input | 1 | `coin_code` carries a coin this cycle |
| item_sel | input | 4 | Requested item number |
| buy | input | 1 | Purchase confirmation |
| item_ready | input | 1 | Preparation unit has finished the item |
| item_out | output | 4 | Item number handed to the preparation unit |
| item_out_valid | output | 1 | `item_out` is valid |
| busy | output | 1 | A sale is in progress |
| change_code | output | 4 | Denomination code of the change being paid |
| change_valid | output | 1 | `change_code` is valid |
| change_done | output | 1 | Change delivery has finished |

## Verification
Sales run with several payment patterns. An exact payment returns no change and shows the bare end pulse. Payments are mixed with illegal coin codes, which prove that those codes add nothing. Every denomination is used to exercise each coin value and a two-code change tail. A single 200-unit note gives a long greedy run. Two back-to-back 200-unit notes can only return the expected change if the credit saturates. The cycle on which delivery starts is compared with a count taken from the price, which separates the "leave on first covering edge" rule from off-by-one variants. Rejected selections and a long wait on `item_ready` cover the idle and hold rules.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    ST_SELECT  = 2'd0,
    ST_PAY     = 2'd1,
    ST_DELIVER = 2'd2,
    ST_CHANGE  = 2'd3
  } vend_state_e;

  localparam int TOP_COIN = 7;

  // Value in units of a denomination code; unknown codes are worth nothing.
  function automatic int coin_value(input logic [3:0] c);
    case (c)
      4'd1:    return 1;
      4'd2:    return 2;
      4'd3:    return 5;
      4'd4:    return 10;
      4'd5:    return 20;
      4'd6:    return 50;
      4'd7:    return 200;
      default: return 0;
    endcase
  endfunction

  // Price of item n (n counted from 1).
  function automatic int item_price(input int n);
    return 10 * n + 5;
  endfunction

  // Largest denomination code whose value does not exceed rem; 0 if none.
  function automatic logic [3:0] greedy_code(input int rem);
    logic [3:0] pick;
    logic       found;
    pick  = 4'd0;
    found = 1'b0;
    for (int c = TOP_COIN; c >= 1; c--) begin
      if (!found && coin_value(4'(c)) <= rem) begin
        pick  = 4'(c);
        found = 1'b1;
      end
    end
    return pick;
  endfunction

endpackage

// File: rtl/vend_price_lut.sv
module vend_price_lut
  import vend_pkg::*;
#(
  parameter int PROD_W   = 4,
  parameter int CREDIT_W = 8,
  parameter int N_ITEMS  = 8
) (
  input  logic [PROD_W-1:0]   code,
  output logic                code_ok,
  output logic [CREDIT_W-1:0] price
);
  localparam int IDX_W = (N_ITEMS > 1) ? $clog2(N_ITEMS) : 1;

  logic [CREDIT_W-1:0] tbl [N_ITEMS];
  logic [IDX_W-1:0]    idx;

  for (genvar g = 0; g < N_ITEMS; g++) begin : g_price
    assign tbl[g] = CREDIT_W'(item_price(g + 1));
  end

  assign code_ok = (code != '0) && (int'(code) <= N_ITEMS);
  assign idx     = IDX_W'(code - 1'b1);
  assign price   = code_ok ? tbl[idx] : '0;

  always_comb begin
    if (code_ok) assert (int'(price) == item_price(int'(code)))
      else $error("assert_price_R4: table entry mismatch");
  end
endmodule

// File: rtl/vend_credit_acc.sv
module vend_credit_acc
  import vend_pkg::*;
#(
  parameter int COIN_W   = 4,
  parameter int CREDIT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                acc_en,
  input  logic [COIN_W-1:0]   coin_code,
  input  logic                coin_valid,
  output logic [CREDIT_W-1:0] credit,
  output logic                coin_hit
);
  logic [CREDIT_W-1:0] add_val;
  logic [CREDIT_W:0]   sum;
  logic                sat_hit;

  assign add_val  = CREDIT_W'(coin_value(4'(coin_code)));
  assign coin_hit = acc_en && coin_valid && (add_val != '0);
  assign sum      = {1'b0, credit} + {1'b0, add_val};
  assign sat_hit  = sum[CREDIT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        credit <= '0;
    else if (clear)    credit <= '0;
    else if (coin_hit) credit <= sat_hit ? '1 : sum[CREDIT_W-1:0];
  end

  assert_credit_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (coin_hit && !clear) |=> (credit >= $past(credit)))
    else $error("credit decreased on a coin");

  assert_no_coin_outside_pay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !clear) |=> $stable(credit))
    else $error("credit moved outside payment phase");
endmodule

// File: rtl/vend_change_unit.sv
module vend_change_unit
  import vend_pkg::*;
#(
  parameter int COIN_W   = 4,
  parameter int CREDIT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CREDIT_W-1:0] load_amt,
  input  logic                step,
  output logic [COIN_W-1:0]   cur_code,
  output logic                empty
);
  logic [CREDIT_W-1:0] remaining;
  logic [CREDIT_W-1:0] cur_val;

  assign cur_code = COIN_W'(greedy_code(int'(remaining)));
  assign cur_val  = CREDIT_W'(coin_value(4'(cur_code)));
  assign empty    = (remaining == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    remaining <= '0;
    else if (load) remaining <= load_amt;
    else if (step) remaining <= remaining - cur_val;
  end

  assert_change_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (remaining < $past(remaining)))
    else $error("owed amount did not shrink");

  assert_pick_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> (cur_val != '0 && cur_val <= remaining))
    else $error("picked denomination does not fit");
endmodule

// File: rtl/vend_order_ctrl.sv
module vend_order_ctrl
  import vend_pkg::*;
#(
  parameter int PROD_W   = 4,
  parameter int COIN_W   = 4,
  parameter int CREDIT_W = 8,
  parameter int N_ITEMS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COIN_W-1:0] coin_code,
  input  logic              coin_valid,
  input  logic [PROD_W-1:0] item_sel,
  input  logic              buy,
  input  logic              item_ready,
  output logic [PROD_W-1:0] item_out,
  output logic              item_out_valid,
  output logic              busy,
  output logic [COIN_W-1:0] change_code,
  output logic              change_valid,
  output logic              change_done
);
  vend_state_e         state, state_nx;
  logic [PROD_W-1:0]   item_q;
  logic [CREDIT_W-1:0] credit, price, change_amt;
  logic                sel_ok, unused_ok, coin_hit;
  logic                credit_enough, change_empty;
  logic [COIN_W-1:0]   pick_code;

  // Named internal events
  logic ev_accept, ev_paid, ev_ready, ev_finish;

  vend_price_lut #(.PROD_W(PROD_W), .CREDIT_W(CREDIT_W), .N_ITEMS(N_ITEMS))
    u_sel_check (.code(item_sel), .code_ok(sel_ok), .price());

  vend_price_lut #(.PROD_W(PROD_W), .CREDIT_W(CREDIT_W), .N_ITEMS(N_ITEMS))
    u_price (.code(item_q), .code_ok(unused_ok), .price(price));

  vend_credit_acc #(.COIN_W(COIN_W), .CREDIT_W(CREDIT_W)) u_credit (
    .clk(clk), .rst_n(rst_n),
    .clear(state == ST_SELECT),
    .acc_en(state == ST_PAY),
    .coin_code(coin_code), .coin_valid(coin_valid),
    .credit(credit), .coin_hit(coin_hit)
  );

  assign credit_enough = (credit >= price);
  assign change_amt    = credit_enough ? (credit - price) : '0;

  vend_change_unit #(.COIN_W(COIN_W), .CREDIT_W(CREDIT_W)) u_change (
    .clk(clk), .rst_n(rst_n),
    .load(state == ST_DELIVER),
    .load_amt(change_amt),
    .step(change_valid),
    .cur_code(pick_code),
    .empty(change_empty)
  );

  assign ev_accept = (state == ST_SELECT)  && buy && sel_ok;
  assign ev_paid   = (state == ST_PAY)     && credit_enough;
  assign ev_ready  = (state == ST_DELIVER) && item_ready;
  assign ev_finish = (state == ST_CHANGE)  && change_empty;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_SELECT:  if (ev_accept) state_nx = ST_PAY;
      ST_PAY:     if (ev_paid)   state_nx = ST_DELIVER;
      ST_DELIVER: if (ev_ready)  state_nx = ST_CHANGE;
      ST_CHANGE:  if (ev_finish) state_nx = ST_SELECT;
      default:                   state_nx = ST_SELECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_SELECT;
      item_q <= '0;
    end else begin
      state <= state_nx;
      if (ev_accept) item_q <= item_sel;
    end
  end

  // Moore output decode
  assign busy           = (state != ST_SELECT);
  assign item_out_valid = (state == ST_DELIVER);
  assign item_out       = item_out_valid ? item_q : '0;
  assign change_valid   = (state == ST_CHANGE) && !change_empty;
  assign change_code    = change_valid ? pick_code : '0;
  assign change_done    = ev_finish;

  assert_reject_bad_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(buy && sel_ok)) |=> !busy)
    else $error("left idle without a legal purchase");

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    item_out_valid |-> !change_valid)
    else $error("item and change valid together");

  assert_item_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (item_out_valid && !item_ready) |=> (item_out_valid && $stable(item_out)))
    else $error("item dropped before ready");

  assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    change_done |=> (!busy && !change_done))
    else $error("not idle after end of change");

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!item_out_valid && !change_valid && !change_done))
    else $error("strobe while idle");

  assert_paid_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    item_out_valid |-> credit_enough)
    else $error("delivery without enough credit");
endmodule

// File: tb/vend_order_ctrl_test.sv
module vend_order_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] coin_code = '0;
  logic       coin_valid = 1'b0;
  logic [3:0] item_sel = '0;
  logic       buy = 1'b0;
  logic       item_ready = 1'b0;
  logic [3:0] item_out, change_code;
  logic       item_out_valid, busy, change_valid, change_done;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_q[$];
  string      cur_req = "R7";

  always #4 clk = ~clk;

  vend_order_ctrl uut (
    .clk(clk), .rst_n(rst_n), .coin_code(coin_code), .coin_valid(coin_valid),
    .item_sel(item_sel), .buy(buy), .item_ready(item_ready),
    .item_out(item_out), .item_out_valid(item_out_valid), .busy(busy),
    .change_code(change_code), .change_valid(change_valid), .change_done(change_done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bench-side denomination table, largest first.
  int dv[7] = '{200, 50, 20, 10, 5, 2, 1};
  int dc[7] = '{7, 6, 5, 4, 3, 2, 1};

  function automatic int worth(input int code);
    for (int i = 0; i < 7; i++) if (dc[i] == code) return dv[i];
    return 0;
  endfunction

  // Monitor: pop expected change codes as the design emits them.
  always @(negedge clk) begin
    if (rst_n && change_valid) begin
      if (exp_q.size() == 0) check("R7 extra code", int'(change_code), 0);
      else check("R7", int'(change_code), int'(exp_q.pop_front()));
    end
  end

  task automatic try_reject(input int code, input logic b);
    @(negedge clk);
    item_sel = 4'(code); buy = b;
    @(negedge clk);
    buy = 1'b0;
    check("R2 reject", int'(busy), 0);
  endtask

  // One complete sale; coins are driven on consecutive cycles.
  task automatic sale(input int item, input int coins[]);
    int price = 10 * item + 5;
    int cred = 0;
    int k = -1;
    int chg, rem, seen;
    for (int e = 0; e < 64 && k < 0; e++) begin
      logic ex = (cred >= price);
      if (e < coins.size()) begin
        cred += worth(coins[e]);
        if (cred > 255) cred = 255;
      end
      if (ex) k = e;
    end
    @(negedge clk);
    item_sel = 4'(item); buy = 1'b1;
    @(negedge clk);
    buy = 1'b0;
    check("R2 accept", int'(busy), 1);
    seen = -1;
    for (int e = 0; e < 64; e++) begin
      if (e < coins.size()) begin coin_code = 4'(coins[e]); coin_valid = 1'b1; end
      else coin_valid = 1'b0;
      @(negedge clk);
      if (seen < 0 && item_out_valid) seen = e;
      if (seen < 0) check("R9 busy paying", int'(busy), 1);
      if (seen >= 0 && e >= coins.size()) break;
    end
    coin_valid = 1'b0;
    check("R4 exit cycle", seen, k);
    for (int w = 0; w < 3; w++) begin
      check("R6 item held", int'(item_out_valid), 1);
      check("R6 item code", int'(item_out), item);
      check("R6 no change yet", int'(change_valid), 0);
      @(negedge clk);
    end
    chg = cred - price;
    rem = chg;
    for (int i = 0; i < 7; i++)
      while (rem >= dv[i]) begin exp_q.push_back(4'(dc[i])); rem -= dv[i]; end
    item_ready = 1'b1;
    @(negedge clk);
    item_ready = 1'b0;
    for (int w = 0; w < 20 && !change_done; w++) begin
      check("R9 busy in change", int'(busy), 1);
      @(negedge clk);
    end
    check("R8 end pulse", int'(change_done), 1);
    check("R7 all change paid", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    check("R8 idle after end", int'(busy), 0);
    check("R8 single pulse", int'(change_done), 0);
  endtask

  initial begin
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 item valid", int'(item_out_valid), 0);
    check("R1 change valid", int'(change_valid), 0);
    check("R1 done", int'(change_done), 0);
    check("R1 codes", int'(item_out) + int'(change_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    try_reject(3, 1'b0);
    try_reject(0, 1'b1);
    try_reject(9, 1'b1);
    try_reject(15, 1'b1);
    sale(1, '{4, 3});                    // R4 exact pay, R8 zero change
    sale(8, '{9, 6, 0, 5, 15, 5});       // R3 illegal codes ignored
    sale(4, '{2, 1, 3, 4, 5, 4});        // R3 every small value
    sale(5, '{7});                       // R7 long greedy run
    sale(8, '{7, 7});                    // R5 saturation
    sale(2, '{5, 5, 5, 5});              // R4 coins after exit ignored
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule